// File: doc/BRIEF.md
# Short-form branch and loop resolver

This block resolves one 16-bit compact branch per strobe. The instruction word holds a 4-bit register index in bits [15:12] and a 4-bit displacement in bits [11:8]. A decoded operation code selects the condition. The block drives the register index back to the register file. It then receives three 32-bit operands: the data register at that index, the address register at that index, and data register 15, which serves as the implicit second operand. From these it produces a taken flag, a branch target and the next PC.

The loop operation decrements the selected address register and always writes the result back. It branches backward unless the result is all ones. All results are registered one cycle after the input strobe. They are qualified by a one-cycle output strobe and are held until the next strobe.

Top module: `sbr_resolve`

## Requirements
- R1: After reset, out_valid, taken, err and wb_en are 0, and target, next_pc, wb_data and wb_idx are 0.
- R2: out_valid is 1 in the cycle after each cycle with in_valid = 1, and 0 otherwise. While in_valid is 0, taken, target and next_pc keep their values.
- R3: Code 0 (equal) is taken when the selected data register equals data register 15. Code 1 (not equal) is taken when they differ.
- R4: The zero tests work as follows. Code 2 is taken when the selected data register is zero, and code 3 when it is non-zero. Code 4 is taken when the selected address register is zero, and code 5 when it is non-zero.
- R5: Codes 6, 7, 8 and 9 compare the selected data register with zero as a signed 32-bit value. They are taken on >= 0, > 0, <= 0 and < 0 respectively.
- R6: For codes 0 to 9, target = pc + 2*disp, with the 4-bit displacement zero-extended.
- R7: Code 10 (loop) gives wb_en = 1 for one cycle, together with out_valid. It also gives wb_data = address register - 1 and wb_idx = instr[15:12]. Every other code leaves wb_en at 0.
- R8: Code 10 is taken unless the decremented value is 0xFFFFFFFF. Its target is pc + 2*disp - 32.
- R9: next_pc equals target when taken is 1, and pc + 2 when taken is 0.
- R10: Codes 11 to 15 give err = 1 for one cycle, together with out_valid. They also give taken = 0, target = pc + 2, next_pc = pc + 2 and wb_en = 0.
- R11: rd_idx equals instr[15:12] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| op | input | 4 | Decoded operation code |
| instr | input | 16 | Instruction word |
| pc | input | 32 | Address of the branch |
| dreg | input | 32 | Selected data register value |
| areg | input | 32 | Selected address register value |
| dimp | input | 32 | Data register 15 value |
| rd_idx | output | 4 | Register index to the register file |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Branch taken |
| target | output | 32 | Branch target |
| next_pc | output | 32 | Next PC |
| wb_en | output | 1 | Loop write-back enable |
| wb_idx | output | 4 | Write-back register index |
| wb_data | output | 32 | Decremented address register |
| err | output | 1 | Unrecognised operation |

## Verification
rd_idx is combinational, so the bench checks it in the same cycle that instr is driven. Every other result is due one rising edge after the strobe. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It takes a second sample after an idle cycle, which confirms that out_valid, err and wb_en have dropped while taken, target and next_pc are held.

// File: rtl/sbr_resolve.sv
module sbr_resolve #(
  parameter int XLEN = 32,
  parameter int PCW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [15:0]     instr,
  input  logic [PCW-1:0]  pc,
  input  logic [XLEN-1:0] dreg,
  input  logic [XLEN-1:0] areg,
  input  logic [XLEN-1:0] dimp,
  output logic [3:0]      rd_idx,
  output logic            out_valid,
  output logic            taken,
  output logic [PCW-1:0]  target,
  output logic [PCW-1:0]  next_pc,
  output logic            wb_en,
  output logic [3:0]      wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            err
);
  localparam logic [3:0] OP_LOOP = 4'd10;

  logic [3:0]      disp;
  logic [PCW-1:0]  seq_pc, fwd_pc, back_pc, tgt_c;
  logic [XLEN-1:0] dec;
  logic            cond, bad;

  assign disp    = instr[11:8];
  assign rd_idx  = instr[15:12];
  assign seq_pc  = pc + PCW'(2);
  assign fwd_pc  = pc + PCW'({disp, 1'b0});
  assign back_pc = fwd_pc - PCW'(32);
  assign dec     = areg - XLEN'(1);

  always_comb begin
    cond = 1'b0;
    bad  = 1'b0;
    case (op)
      4'd0: cond = (dreg == dimp);
      4'd1: cond = (dreg != dimp);
      4'd2: cond = (dreg == '0);
      4'd3: cond = (dreg != '0);
      4'd4: cond = (areg == '0);
      4'd5: cond = (areg != '0);
      4'd6: cond = !dreg[XLEN-1];
      4'd7: cond = !dreg[XLEN-1] && (dreg != '0);
      4'd8: cond = dreg[XLEN-1] || (dreg == '0);
      4'd9: cond = dreg[XLEN-1];
      OP_LOOP: cond = (dec != '1);
      default: bad = 1'b1;
    endcase
  end

  assign tgt_c = bad ? seq_pc : (op == OP_LOOP) ? back_pc : fwd_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      target    <= '0;
      next_pc   <= '0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      err       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      err       <= in_valid && bad;
      wb_en     <= in_valid && (op == OP_LOOP);
      if (in_valid) begin
        taken   <= cond;
        target  <= tgt_c;
        next_pc <= cond ? tgt_c : seq_pc;
        if (op == OP_LOOP) begin
          wb_idx  <= rd_idx;
          wb_data <= dec;
        end
      end
    end
  end
endmodule

module sbr_resolve_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic [15:0] instr,
  input logic [31:0] pc,
  input logic [31:0] areg,
  input logic        out_valid,
  input logic        taken,
  input logic [31:0] target,
  input logic [31:0] next_pc,
  input logic        wb_en,
  input logic [31:0] wb_data,
  input logic        err
);
  a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(taken) && $stable(target) && $stable(next_pc));
  a_r7_wb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd10 |=> wb_en && wb_data == $past(areg) - 32'd1);
  a_r7_wb_only_loop: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid && !err);
  a_r8_back: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd10 |=> target == $past(pc) + {27'd0, $past(instr[11:8]), 1'b0} - 32'd32);
  a_r9_seq: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> taken || next_pc == $past(pc) + 32'd2);
  a_r10_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> out_valid && !taken && !wb_en);
endmodule

bind sbr_resolve sbr_resolve_chk i_chk (
  .clk, .rst_n, .in_valid, .op, .instr, .pc, .areg,
  .out_valid, .taken, .target, .next_pc, .wb_en, .wb_data, .err
);

// File: tb/test_sbr_resolve.sv
module test_sbr_resolve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] instr = '0;
  logic [31:0] pc = '0, dreg = '0, areg = '0, dimp = '0;
  logic [3:0]  rd_idx, wb_idx;
  logic        out_valid, taken, wb_en, err;
  logic [31:0] target, next_pc, wb_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sbr_resolve i_sbr_resolve (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [3:0] o, input logic [31:0] d, input logic [31:0] a, input logic [31:0] i);
    case (o)
      4'd0: return d == i;
      4'd1: return d != i;
      4'd2: return d == 0;
      4'd3: return d != 0;
      4'd4: return a == 0;
      4'd5: return a != 0;
      4'd6: return $signed(d) >= 0;
      4'd7: return $signed(d) > 0;
      4'd8: return $signed(d) <= 0;
      4'd9: return $signed(d) < 0;
      4'd10: return (a - 1) != 32'hFFFF_FFFF;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    if (o <= 1) return "R3";
    if (o <= 5) return "R4";
    if (o <= 9) return "R5";
    if (o == 10) return "R8";
    return "R10";
  endfunction

  task automatic apply(input logic [3:0] o, input logic [3:0] idx, input logic [3:0] dsp,
                       input logic [31:0] p, input logic [31:0] d, input logic [31:0] a, input logic [31:0] i);
    logic [31:0] et, enx;
    bit tk;
    @(negedge clk);
    in_valid = 1; op = o; instr = {idx, dsp, 8'h5A}; pc = p; dreg = d; areg = a; dimp = i;
    #0.5 chk("R11", "rd_idx", 32'(rd_idx), 32'(idx));
    tk  = exp_taken(o, d, a, i);
    et  = (o > 10) ? p + 2 : (o == 10) ? p + {dsp, 1'b0} - 32 : p + {dsp, 1'b0};
    enx = tk ? et : p + 2;
    @(posedge clk); #1;
    chk("R2", "out_valid", 32'(out_valid), 1);
    chk(req_of(o), "taken", 32'(taken), 32'(tk));
    chk((o == 10) ? "R8" : (o > 10) ? "R10" : "R6", "target", target, et);
    chk("R9", "next_pc", next_pc, enx);
    chk("R7", "wb_en", 32'(wb_en), 32'(o == 10));
    if (o == 10) begin
      chk("R7", "wb_data", wb_data, a - 1);
      chk("R7", "wb_idx", 32'(wb_idx), 32'(idx));
    end
    chk("R10", "err", 32'(err), 32'(o > 10));
    @(negedge clk);
    in_valid = 0; dreg = ~dreg; pc = pc + 32'h100;
    @(posedge clk); #1;
    chk("R2", "out_valid idle", 32'(out_valid), 0);
    chk("R2", "taken held", 32'(taken), 32'(tk));
    chk("R2", "target held", target, et);
    chk("R2", "next_pc held", next_pc, enx);
    chk("R7", "wb_en idle", 32'(wb_en), 0);
    chk("R10", "err idle", 32'(err), 0);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 4))
      0: return 0;
      1: return 1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "taken", 32'(taken), 0);
    chk("R1", "target", target, 0);
    chk("R1", "next_pc", next_pc, 0);
    chk("R1", "wb", {wb_data[30:0], wb_en}, 0);
    chk("R1", "err", 32'(err), 0);
    @(negedge clk); rst_n = 1;
    // directed corners
    apply(4'd0, 4'd3, 4'd7, 32'h1000, 32'h55, 32'h0, 32'h55);
    apply(4'd1, 4'd3, 4'd7, 32'h1000, 32'h55, 32'h0, 32'h55);
    apply(4'd2, 4'd1, 4'd0, 32'h2000, 32'h0, 32'h9, 32'h1);
    apply(4'd4, 4'd2, 4'd15, 32'h2000, 32'h9, 32'h0, 32'h1);
    apply(4'd5, 4'd2, 4'd15, 32'h2000, 32'h0, 32'h0, 32'h1);
    apply(4'd6, 4'd0, 4'd1, 32'h3000, 32'h0, 32'h1, 32'h1);
    apply(4'd7, 4'd0, 4'd1, 32'h3000, 32'h0, 32'h1, 32'h1);
    apply(4'd8, 4'd0, 4'd1, 32'h3000, 32'h0, 32'h1, 32'h1);
    apply(4'd9, 4'd0, 4'd1, 32'h3000, 32'h8000_0000, 32'h1, 32'h1);
    apply(4'd7, 4'd0, 4'd1, 32'h3000, 32'h7FFF_FFFF, 32'h1, 32'h1);
    apply(4'd10, 4'd6, 4'd0, 32'h4000, 32'h0, 32'h0, 32'h0);
    apply(4'd10, 4'd6, 4'd15, 32'h4000, 32'h0, 32'h2, 32'h0);
    apply(4'd10, 4'd9, 4'd4, 32'h4000, 32'h0, 32'h1, 32'h0);
    apply(4'd11, 4'd9, 4'd4, 32'h5000, 32'h0, 32'h1, 32'h0);
    apply(4'd15, 4'd9, 4'd4, 32'h5000, 32'h0, 32'h1, 32'h0);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] d;
      d = pick();
      apply(4'($urandom_range(0, 15)), 4'($urandom), 4'($urandom), {$urandom, 1'b0},
            d, pick(), ($urandom_range(0, 1) != 0) ? d : pick());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule